// File: doc/BRIEF.md
# Receive FIFO RTS Flow Controller

This block produces the active-low request-to-send line of a UART receiver from two inputs: how full its receive FIFO is, and how far the receiver has got with the character now arriving. Its purpose is to stop a remote transmitter before the FIFO can overflow. It withdraws the request early, at the moment the receiver samples the first data bit of the character that will take the last free slot. A remote sender that reacts at its next character boundary then never pushes more than the FIFO can hold.

The request comes back in two cases. The first is when enough space is free: two or more slots, or one slot with no character on the wire. The second is the first host read of the receive holding register while the FIFO is full. When automatic flow control is off, the line simply follows a software request bit. The receiver shifter, the FIFO storage and the host register decode are outside this block. They reach it as a fill count and single-cycle event pulses.

Top module: `rx_rts_flow`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rts_n` is 1 (de-asserted), whatever the other inputs are.
- R2: With `auto_en` = 0, `rts_n` takes the value `~sw_rts` one clock after it is sampled. Fill level and event pulses have no effect in this mode.
- R3: With `auto_en` = 1, a `first_bit` pulse while `fill` >= DEPTH-1 (15 of 16) sets `rts_n` to 1 on the next clock. This holds whatever the other inputs are.
- R4: With `auto_en` = 1 and `fill` <= DEPTH-2 (at least two free slots), `rts_n` is 0 on the next clock, whether or not a character is in progress.
- R5: With `auto_en` = 1, `fill` = DEPTH-1 and no `first_bit` pulse, `rts_n` goes to 0 on the next clock if no character is in progress. It keeps its previous value if a character is in progress.
- R6: With `auto_en` = 1 and `fill` = DEPTH (full), a `host_rd` pulse with no `first_bit` pulse sets `rts_n` to 0 on the next clock. Without a read, `rts_n` keeps its value.
- R7: The character-in-progress flag is set by a `start_det` pulse, and cleared by a `char_done` or `char_drop` pulse when no `start_det` pulse comes in the same cycle. It is only visible through R5.
- R8: The depth is the parameter DEPTH, default 16, and `fill` counts from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_en | input | 1 | 1 selects automatic flow control |
| sw_rts | input | 1 | Software request bit, 1 = request, used when auto_en is 0 |
| fill | input | $clog2(DEPTH+1) | Current receive FIFO occupancy |
| start_det | input | 1 | Pulse: start bit of a new character detected |
| first_bit | input | 1 | Pulse: first data bit of the current character sampled |
| char_done | input | 1 | Pulse: character written into the FIFO |
| char_drop | input | 1 | Pulse: character discarded |
| host_rd | input | 1 | Pulse: host read of the receive holding register |
| rts_n | output | 1 | Request to send, active low, registered |

## Verification
The main sweep covers every fill level from empty to full. It crosses each level with both settings of the character-in-progress flag, both previous line states, and all four combinations of the first-data-bit and host-read pulses. The previous line state is what separates holding (R5, R6 without a read) from forcing a value (R3, R4, R6 with a read). The flag setting is what separates the one-slot rule from the two-slot rule. Separate short sequences cover manual mode with both request values, the reset value, and clearing the flag by a discarded character rather than a written one.

// File: rtl/rx_rts_flow.sv
module rx_rts_flow #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          sw_rts,
  input  logic [CW-1:0] fill,
  input  logic          start_det,
  input  logic          first_bit,
  input  logic          char_done,
  input  logic          char_drop,
  input  logic          host_rd,
  output logic          rts_n
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
  localparam logic [CW-1:0] ROOM2 = CW'(DEPTH - 2);

  logic busy;
  logic req, req_nx;

  wire near_full = fill >= LAST;
  wire is_full   = fill == FULL;
  wire space_ok  = (fill <= ROOM2) || (fill == LAST && !busy);

  always_ff @(posedge clk) begin
    if (!rst_n)                       busy <= 1'b0;
    else if (start_det)               busy <= 1'b1;
    else if (char_done || char_drop)  busy <= 1'b0;
  end

  always_comb begin
    req_nx = req;
    if (!auto_en)                     req_nx = sw_rts;
    else if (first_bit && near_full)  req_nx = 1'b0;
    else if (is_full)                 req_nx = host_rd ? 1'b1 : req;
    else if (space_ok)                req_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_nx;
  end

  assign rts_n = ~req;
endmodule

module rx_rts_flow_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_en,
  input logic          sw_rts,
  input logic [CW-1:0] fill,
  input logic          start_det,
  input logic          first_bit,
  input logic          char_done,
  input logic          char_drop,
  input logic          host_rd,
  input logic          busy,
  input logic          rts_n
);
  a_r2_manual: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> rts_n == !$past(sw_rts));

  a_r3_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && first_bit && fill >= CW'(DEPTH - 1) |=> rts_n);

  a_r4_two_free: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && fill <= CW'(DEPTH - 2) |=> !rts_n);

  a_r5_one_free_idle: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && fill == CW'(DEPTH - 1) && !first_bit && !busy |=> !rts_n);

  a_r5_one_free_busy: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && fill == CW'(DEPTH - 1) && !first_bit && busy |=> $stable(rts_n));

  a_r6_full_read: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && fill == CW'(DEPTH) && host_rd && !first_bit |=> !rts_n);

  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && fill == CW'(DEPTH) && !host_rd && !first_bit |=> $stable(rts_n));

  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done || char_drop) && !start_det |=> !busy);
endmodule

bind rx_rts_flow rx_rts_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sw_rts(sw_rts), .fill(fill),
  .start_det(start_det), .first_bit(first_bit), .char_done(char_done),
  .char_drop(char_drop), .host_rd(host_rd), .busy(busy), .rts_n(rts_n)
);

// File: tb/sim_rx_rts_flow.sv
`timescale 1ns/1ps
module sim_rx_rts_flow;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, auto_en = 0, sw_rts = 0;
  logic [CW-1:0] fill = '0;
  logic start_det = 0, first_bit = 0, char_done = 0, char_drop = 0, host_rd = 0;
  logic rts_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_rts_flow #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sw_rts(sw_rts), .fill(fill),
    .start_det(start_det), .first_bit(first_bit), .char_done(char_done),
    .char_drop(char_drop), .host_rd(host_rd), .rts_n(rts_n)
  );

  task automatic check(string req, logic exp);
    checks++;
    if (rts_n !== exp) begin
      failures++;
      $display("FAIL %s rts_n=%b expected=%b", req, rts_n, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    start_det = 0; first_bit = 0; char_done = 0; char_drop = 0; host_rd = 0;
  endtask

  // Put line in state on (prev=1) or off, and flag to bsy, in one cycle.
  task automatic prep(bit prev, bit bsy);
    idle();
    fill = '0;
    if (prev) begin auto_en = 1; end
    else begin auto_en = 0; sw_rts = 0; end
    start_det = bsy; char_done = !bsy;
    step();
  endtask

  function automatic logic model(int f, bit bsy, bit prev, bit fb, bit rd);
    bit on;
    if (fb && f >= DEPTH - 1)          on = 0;
    else if (f == DEPTH)               on = rd ? 1'b1 : prev;
    else if ((DEPTH - f) >= 2)         on = 1;
    else if (!bsy)                     on = 1;
    else                               on = prev;
    return !on;
  endfunction

  function automatic string tag(int f, bit fb);
    if (fb && f >= DEPTH - 1) return "R3";
    if (f == DEPTH)           return "R6";
    if (f == DEPTH - 1)       return "R5";
    return "R4";
  endfunction

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset holds the line de-asserted even with a request pending
    auto_en = 1; fill = '0;
    @(negedge clk); @(negedge clk);
    check("R1", 1'b1);
    rst_n = 1;
    check("R1", 1'b1);
    step();
    check("R4", 1'b0);

    // R2: manual mode, fill and pulses ignored
    for (int s = 0; s < 2; s++) begin
      idle(); auto_en = 0; sw_rts = s[0]; fill = CW'(DEPTH); first_bit = 1; host_rd = 1;
      step();
      check("R2", !s[0]);
      fill = '0; first_bit = 0; host_rd = 0;
      step();
      check("R2", !s[0]);
    end

    // R3..R6, R8: sweep of all fill levels
    for (int f = 0; f <= DEPTH; f++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          for (int fb = 0; fb < 2; fb++)
            for (int rd = 0; rd < 2; rd++) begin
              prep(p[0], b[0]);
              idle(); auto_en = 1; fill = CW'(f); first_bit = fb[0]; host_rd = rd[0];
              step();
              check(tag(f, fb[0]), model(f, b[0], p[0], fb[0], rd[0]));
            end

    // R7: a discarded character clears the in-progress flag
    prep(1'b0, 1'b1);
    idle(); auto_en = 1; fill = CW'(DEPTH - 1);
    step();
    check("R7", 1'b1);
    char_drop = 1;
    step();
    char_drop = 0;
    step();
    check("R7", 1'b0);
    // R7: start wins over drop in the same cycle
    prep(1'b0, 1'b0);
    idle(); auto_en = 0; sw_rts = 0; start_det = 1; char_drop = 1;
    step();
    idle(); auto_en = 1; fill = CW'(DEPTH - 1);
    step();
    check("R7", 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule